// File: doc/BRIEF.md
# Multi-Cycle Element Serializer

This block takes a group of equal-width elements that arrive side by side and plays them out one after another on a single output lane. Each element is made of several consecutive parts, one part per cycle. During the first element slot of a pass, the upstream side presents part p of every element at the same time. The block forwards element 0's part straight to the output and keeps the parts of every other element. In the later slots it replays the kept parts in element order. A full pass therefore takes one output transfer for every element part, and the next pass starts right after the last one.

Both sides use a ready/valid handshake, and a clock enable gates all progress. Upstream is asked for data only while element 0 is on the output. The kept data then plays out with no further input. A pause on the downstream ready, on the clock enable, or on the upstream valid (in the first slot only) freezes the position in the pass.

Top module: `mcyc_serializer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the block is at element 0 part 0. With `ce`=1, `ready_down`=1 and `valid_up`=0, this shows as `ready_up`=1, `valid_down`=0 and `out_data` equal to input lane 0.
- R2: Across accepted output transfers, the data comes out as element 0 parts 0..T-1, then element 1 parts 0..T-1, and so on up to element N-1. That is N×T transfers per pass.
- R3: `ready_up` is 1 only while element 0 is on the output, and only when `ce` and `ready_down` are both 1. It is 0 throughout the slots of elements 1..N-1.
- R4: In the element 0 slot, `valid_down` equals `valid_up`. In every later slot, `valid_down` is 1.
- R5: In the element 0 slot, `out_data` equals input lane 0 (`in_data` bits [W-1:0]) in the same cycle, with no register in the path.
- R6: Element j (j ≥ 1) is taken from `in_data` bits [j·W+W-1 : j·W] on the cycle its part is accepted. Later changes of `in_data` do not alter what element j plays out.
- R7: A cycle with `ce`=0, or `ready_down`=0, or (in the element 0 slot) `valid_up`=0 leaves the position in the pass unchanged. In a later slot, `out_data` then keeps showing the same part.
- R8: After the transfer of the last part of element N-1, the very next cycle is element 0 part 0 of a new pass, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; progress happens only when 1 |
| in_data | input | N_ELEM*ELEM_W | All elements side by side; element j in bits [j*ELEM_W +: ELEM_W] |
| valid_up | input | 1 | Upstream has data on `in_data` |
| ready_up | output | 1 | Block takes `in_data` this cycle |
| out_data | output | ELEM_W | Current part on the output lane |
| valid_down | output | 1 | `out_data` carries a part |
| ready_down | input | 1 | Downstream takes `out_data` this cycle |

## Verification
In the element 0 slot, `out_data`, `valid_down` and `ready_up` follow the inputs in the same cycle. The bench drives inputs one time unit after a rising edge and samples these outputs at the following falling edge, in the same clock period. A transfer moves the block to the next part at the next rising edge. The replayed data of a later slot is therefore compared at the falling edge of the period after the last accepting edge. Expected words go into a queue when the driver predicts a transfer, and a monitor pops one entry at each falling edge where a transfer is visible. A late, early or skipped advance thus shows up as a mismatch in the stream.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  // counter width for a count range of n values (at least one bit)
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mcs_seq_ctrl.sv
module mcs_seq_ctrl #(
  parameter int N_ELEM  = 4,
  parameter int T_PARTS = 3,
  parameter int EW      = 2,
  parameter int PW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          valid_up,
  input  logic          ready_down,
  output logic [EW-1:0] elem_idx,
  output logic [PW-1:0] part_idx,
  output logic          first_slot,
  output logic          step_en,
  output logic          ready_up,
  output logic          valid_down
);
  localparam logic [EW-1:0] ELEM_LAST = EW'(N_ELEM - 1);
  localparam logic [PW-1:0] PART_LAST = PW'(T_PARTS - 1);

  logic [EW-1:0] elem_q, elem_d;
  logic [PW-1:0] part_q, part_d;

  always_comb begin
    first_slot = (elem_q == '0);
    valid_down = first_slot ? valid_up : 1'b1;
    ready_up   = first_slot & ce & ready_down;
    step_en    = ce & ready_down & valid_down;
  end

  always_comb begin
    elem_d = elem_q;
    part_d = part_q;
    if (step_en) begin
      if (part_q == PART_LAST) begin
        part_d = '0;
        elem_d = (elem_q == ELEM_LAST) ? '0 : elem_q + 1'b1;
      end else begin
        part_d = part_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
      part_q <= '0;
    end else begin
      elem_q <= elem_d;
      part_q <= part_d;
    end
  end

  assign elem_idx = elem_q;
  assign part_idx = part_q;
endmodule

// File: rtl/mcs_capture_store.sv
module mcs_capture_store #(
  parameter int ELEM_W  = 8,
  parameter int N_ELEM  = 4,
  parameter int T_PARTS = 3,
  parameter int EW      = 2,
  parameter int PW      = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture_en,
  input  logic [EW-1:0]            elem_idx,
  input  logic [PW-1:0]            part_idx,
  input  logic [N_ELEM*ELEM_W-1:0] in_data,
  output logic [ELEM_W-1:0]        rd_word
);
  localparam int KEPT = N_ELEM - 1;

  generate
    if (KEPT > 0) begin : g_store
      logic [ELEM_W-1:0] mem_q [KEPT][T_PARTS];
      logic [ELEM_W-1:0] mem_d [KEPT][T_PARTS];

      always_comb begin
        for (int j = 0; j < KEPT; j++)
          for (int p = 0; p < T_PARTS; p++)
            mem_d[j][p] = mem_q[j][p];
        if (capture_en) begin
          for (int j = 0; j < KEPT; j++)
            for (int p = 0; p < T_PARTS; p++)
              if (part_idx == PW'(p))
                mem_d[j][p] = in_data[(j+1)*ELEM_W +: ELEM_W];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int j = 0; j < KEPT; j++)
            for (int p = 0; p < T_PARTS; p++)
              mem_q[j][p] <= '0;
        end else begin
          for (int j = 0; j < KEPT; j++)
            for (int p = 0; p < T_PARTS; p++)
              mem_q[j][p] <= mem_d[j][p];
        end
      end

      always_comb begin
        rd_word = '0;
        for (int j = 0; j < KEPT; j++)
          for (int p = 0; p < T_PARTS; p++)
            if ((elem_idx == EW'(j+1)) && (part_idx == PW'(p)))
              rd_word = mem_q[j][p];
      end
    end else begin : g_nostore
      assign rd_word = '0;
    end
  endgenerate
endmodule

// File: rtl/mcyc_serializer.sv
module mcyc_serializer
  import mcs_pkg::*;
#(
  parameter int ELEM_W  = 8,
  parameter int N_ELEM  = 4,
  parameter int T_PARTS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic [N_ELEM*ELEM_W-1:0] in_data,
  input  logic                     valid_up,
  output logic                     ready_up,
  output logic [ELEM_W-1:0]        out_data,
  output logic                     valid_down,
  input  logic                     ready_down
);
  localparam int EW = cnt_w(N_ELEM);
  localparam int PW = cnt_w(T_PARTS);

  logic [EW-1:0]     elem_idx;
  logic [PW-1:0]     part_idx;
  logic              first_slot;
  logic              step_en;
  logic [ELEM_W-1:0] kept_word;

  mcs_seq_ctrl #(
    .N_ELEM(N_ELEM), .T_PARTS(T_PARTS), .EW(EW), .PW(PW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (ce),
    .valid_up   (valid_up),
    .ready_down (ready_down),
    .elem_idx   (elem_idx),
    .part_idx   (part_idx),
    .first_slot (first_slot),
    .step_en    (step_en),
    .ready_up   (ready_up),
    .valid_down (valid_down)
  );

  mcs_capture_store #(
    .ELEM_W(ELEM_W), .N_ELEM(N_ELEM), .T_PARTS(T_PARTS), .EW(EW), .PW(PW)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (step_en & first_slot),
    .elem_idx   (elem_idx),
    .part_idx   (part_idx),
    .in_data    (in_data),
    .rd_word    (kept_word)
  );

  // element 0 goes straight through; the rest replays from storage
  assign out_data = first_slot ? in_data[ELEM_W-1:0] : kept_word;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int ELEM_W  = 8,
  parameter int N_ELEM  = 4,
  parameter int T_PARTS = 3,
  parameter int EW      = 2,
  parameter int PW      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              valid_up,
  input logic              ready_up,
  input logic              valid_down,
  input logic              ready_down,
  input logic [ELEM_W-1:0] out_data,
  input logic [ELEM_W-1:0] lane0,
  input logic [EW-1:0]     elem,
  input logic [PW-1:0]     part
);
  logic xfer;
  assign xfer = ce & valid_down & ready_down;

  AST_RDY_NEEDS_CE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    ready_up |-> (ce && ready_down)); // R3
  AST_RDY_ONLY_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    ready_up |-> (elem == '0)); // R3
  AST_SLOT0_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (elem == '0) |-> (valid_down == valid_up)); // R4
  AST_LATE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (elem != '0) |-> valid_down); // R4
  AST_SLOT0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ready_up |-> (out_data == lane0)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(elem) && $stable(part))); // R7
  AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && elem != '0) |=> $stable(out_data)); // R7
  AST_PART_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && part != PW'(T_PARTS-1)) |=> (part == $past(part) + 1'b1 && $stable(elem))); // R2
  AST_WRAP_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && part == PW'(T_PARTS-1) && elem == EW'(N_ELEM-1)) |=> (elem == '0 && part == '0)); // R8
endmodule

bind mcyc_serializer mcs_checker #(
  .ELEM_W(ELEM_W), .N_ELEM(N_ELEM), .T_PARTS(T_PARTS), .EW(EW), .PW(PW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce         (ce),
  .valid_up   (valid_up),
  .ready_up   (ready_up),
  .valid_down (valid_down),
  .ready_down (ready_down),
  .out_data   (out_data),
  .lane0      (in_data[ELEM_W-1:0]),
  .elem       (elem_idx),
  .part       (part_idx)
);

// File: tb/mcyc_serializer_tb_top.sv
module mcyc_serializer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 4;
  localparam int T = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ce = 1'b0;
  logic           valid_up = 1'b0;
  logic           ready_down = 1'b0;
  logic [N*W-1:0] din = '0;
  logic           ready_up;
  logic           valid_down;
  logic [W-1:0]   out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [W-1:0] exp_q[$];
  logic [W-1:0] bstore [N][T];
  int m_e = 0;
  int m_p = 0;
  int passes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcyc_serializer #(.ELEM_W(W), .N_ELEM(N), .T_PARTS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .in_data(din), .valid_up(valid_up),
    .ready_up(ready_up), .out_data(out_data), .valid_down(valid_down),
    .ready_down(ready_down)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard monitor: one queue entry per visible transfer (R2 ordering, R6 capture)
  always @(negedge clk) begin
    if (rst_n && ce && ready_down && valid_down) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected transfer", 32'(out_data), 32'hffff_ffff);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R2 stream word", 32'(out_data), 32'(e));
      end
    end
  end

  function automatic logic [W-1:0] pat(input int seed, input int j, input int p);
    return W'(seed * 29 + j * 11 + p * 3 + 1);
  endfunction

  // one clock period: drive, predict, check flags and data
  task automatic step(input logic c, input logic r, input logic v,
                      input logic [N*W-1:0] d, output bit adv);
    logic [W-1:0] eo;
    bit           er, ev;
    @(posedge clk); #1;
    ce = c; ready_down = r; valid_up = v; din = d;
    ev  = (m_e == 0) ? v : 1'b1;
    er  = (m_e == 0) && c && r;
    adv = c && r && ev;
    eo  = (m_e == 0) ? d[W-1:0] : bstore[m_e][m_p];
    if (adv) exp_q.push_back(eo);
    if (adv && m_e == 0)
      for (int j = 1; j < N; j++) bstore[j][m_p] = d[j*W +: W];
    @(negedge clk);
    if (m_e == 0 && m_p == 0 && passes > 0)
      chk(ready_up == er, "R8 ready at new pass", 32'(ready_up), 32'(er));
    else
      chk(ready_up == er, "R3 ready_up", 32'(ready_up), 32'(er));
    chk(valid_down == ev, "R4 valid_down", 32'(valid_down), 32'(ev));
    if (m_e == 0)
      chk(out_data == eo, "R5 lane0 pass-through", 32'(out_data), 32'(eo));
    else if (adv)
      chk(out_data == eo, "R6 replayed part", 32'(out_data), 32'(eo));
    else
      chk(out_data == eo, "R7 held part", 32'(out_data), 32'(eo));
    if (adv) begin
      if (m_p == T - 1) begin
        m_p = 0;
        m_e = (m_e == N - 1) ? 0 : m_e + 1;
        if (m_e == 0) passes++;
      end else begin
        m_p++;
      end
    end
  endtask

  // mode 0: always flowing; mode 1: stalls on every control input
  task automatic run_pass(input int seed, input int mode, input int max_xfer);
    int k = 0;
    int got = 0;
    while (got < max_xfer) begin
      logic c, r, v;
      logic [N*W-1:0] d;
      bit a;
      c = (mode == 0) ? 1'b1 : (k % 3 != 1);
      r = (mode == 0) ? 1'b1 : (k % 4 != 2);
      v = (mode == 0) ? 1'b1 : (k % 5 != 3);
      for (int j = 0; j < N; j++)
        d[j*W +: W] = (m_e == 0) ? pat(seed, j, m_p) : W'(k * 37 + j * 91 + 5);
      step(c, r, v, d, a);
      if (a) got++;
      k++;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; ce = 1'b1; ready_down = 1'b1; valid_up = 1'b0;
    din = {N{W'(8'h5a)}};
    m_e = 0; m_p = 0; passes = 0;
    @(negedge clk);
    chk(ready_up == 1'b1, "R1 ready_up in reset", 32'(ready_up), 32'd1);
    chk(valid_down == 1'b0, "R1 valid_down in reset", 32'(valid_down), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_up == 1'b1, "R1 ready_up after reset", 32'(ready_up), 32'd1);
    chk(valid_down == 1'b0, "R1 valid_down after reset", 32'(valid_down), 32'd0);
    chk(out_data == din[W-1:0], "R1 out lane0 after reset", 32'(out_data), 32'(din[W-1:0]));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    do_reset();
    run_pass(1, 0, N * T);          // R2 single flowing pass
    run_pass(2, 0, N * T);          // R8 back-to-back pass
    run_pass(3, 0, N * T);
    run_pass(4, 1, N * T);          // R7 stalls of all kinds, R6 noisy input
    run_pass(5, 1, N * T);
    run_pass(6, 0, N * T + 2);      // partial next pass, then reset mid-pass
    do_reset();                     // R1 return to element 0 from mid-pass
    exp_q.delete();
    run_pass(7, 0, N * T);
    run_pass(8, 1, N * T);
    repeat (2) begin
      logic [N*W-1:0] d;
      bit a;
      d = '0;
      step(1'b0, 1'b0, 1'b0, d, a);
    end
    chk(exp_q.size() == 0, "R2 all expected words seen", 32'(exp_q.size()), 32'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule